// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block turns access requests from a 32-bit processor core into cycles on an external memory and I/O bus. The core presents a request with direction (read or write), space (memory or I/O), transfer kind (single word or four-word burst), an address and write data. The sequencer runs each bus cycle through named states:

- idle
- a one-cycle address state that raises a cycle-start strobe
- a single-transfer state, or one state per burst beat, that waits on READY
- a hold state in which another master owns the bus

Read data comes back to the core with a pulse for each accepted word, and a done pulse marks the end of the cycle. The block rejects a burst in I/O space and a burst whose address is not 16-byte aligned. It answers such a request with an error pulse and starts no bus cycle.

Bus ownership is given away only at defined points: while idle, and at the end of the final single-transfer state. During a hold the block releases its address, data and control drivers and raises a hold acknowledge. An interrupt request line is sampled only while the bus is idle.

Top module: `xbus_seq`

## Requirements
- R1: In idle, `bus_cs`, `bus_cyc_start` and `bus_data_oe` are low and `bus_status` is 0. `req_ready` is high when `hold_req` is low.
- R2: An accepted request gives exactly one address-state cycle. In that cycle `bus_cyc_start` and `bus_cs` are high, `bus_addr` equals the request address, and `bus_status` = {io, write, burst, 1} (bit 3 = I/O space, bit 2 = write, bit 1 = burst, bit 0 = cycle active). `bus_data_oe` is high only for a single write.
- R3: In the single-transfer state, each clock edge with `bus_ready` low repeats the state with the address held. The edge with `bus_ready` high ends the cycle: the next cycle shows `rsp_beat` and `rsp_done` high, and for a read `rsp_rdata` holds the sampled `bus_rdata`.
- R4: A burst has four beats, k = 0..3. In beat k, `bus_addr` = base + 4k and `beat_idx` = k. For a write, `bus_data_oe` is high and `bus_wdata` = `beat_wdata`. Each beat waits while `bus_ready` is low. Each accepted beat pulses `rsp_beat` one cycle later with its read data. The fourth accepted beat also pulses `rsp_done`.
- R5: A burst request in I/O space, or with address bits [3:0] not zero, gives `rsp_err` high for exactly the cycle after acceptance. `bus_cs` and `bus_cyc_start` stay low.
- R6: `hold_req` sampled high in idle puts the bus in hold on the next cycle. In hold, `hold_ack` = 1, `bus_oe` = 0, `bus_data_oe` = 0 and `req_ready` = 0. A request presented during the hold starts no cycle.
- R7: `hold_req` high on the edge that ends a single transfer moves the bus straight to hold, with no idle cycle between.
- R8: `hold_req` during single-transfer wait states or burst beats has no effect until the cycle ends. After a burst the bus spends one cycle in idle before hold.
- R9: `hold_req` sampled low in hold returns the bus to idle on the next cycle, with `hold_ack` low and `bus_oe` high.
- R10: `irq_seen` takes the value of `irq_in` only on edges in idle. Changes of `irq_in` during a bus cycle leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_burst | input | 1 | 1 = four-word burst |
| req_addr | input | AW | Request byte address |
| req_wdata | input | DW | Write data for a single write |
| req_ready | output | 1 | Request is taken on this edge |
| beat_wdata | input | DW | Write data for the current burst beat |
| beat_idx | output | 2 | Current burst beat number |
| rsp_rdata | output | DW | Last word read |
| rsp_beat | output | 1 | A word was transferred |
| rsp_done | output | 1 | Bus cycle finished |
| rsp_err | output | 1 | Request rejected |
| irq_in | input | 1 | Interrupt request line |
| irq_seen | output | 1 | Interrupt request sampled in idle |
| bus_addr | output | AW | External address |
| bus_wdata | output | DW | External write data |
| bus_rdata | input | DW | External read data |
| bus_data_oe | output | 1 | Write data drive enable |
| bus_oe | output | 1 | Address and control drive enable |
| bus_cyc_start | output | 1 | Bus cycle start strobe |
| bus_cs | output | 1 | Chip select |
| bus_status | output | 4 | Cycle status code |
| bus_ready | input | 1 | Transfer ready / wait control |
| hold_req | input | 1 | Bus hold request |
| hold_ack | output | 1 | Bus hold acknowledge |

## Verification
The assertions assume that the core holds a request stable only while `req_ready` is high, that `bus_ready` matters only in transfer states, and that `hold_req` goes low only after `hold_ack` has been seen. The stimulus obeys these rules. It drops `req_valid` right after the accepting edge and clears `bus_ready` outside transfer states. It releases `hold_req` only after it has seen `hold_ack`. All inputs change on the falling edge, so every sampled value is settled.

// File: rtl/xbus_seq.sv
module xbus_seq #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int BEATS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_io,
  input  logic          req_burst,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  input  logic [DW-1:0] beat_wdata,
  output logic [$clog2(BEATS)-1:0] beat_idx,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_beat,
  output logic          rsp_done,
  output logic          rsp_err,
  input  logic          irq_in,
  output logic          irq_seen,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic          bus_data_oe,
  output logic          bus_oe,
  output logic          bus_cyc_start,
  output logic          bus_cs,
  output logic [3:0]    bus_status,
  input  logic          bus_ready,
  input  logic          hold_req,
  output logic          hold_ack
);
  localparam int LB  = $clog2(DW / 8);
  localparam int CW  = $clog2(BEATS);
  localparam int ALB = $clog2(BEATS * DW / 8);
  localparam logic [CW-1:0] LAST = CW'(BEATS - 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_SNGL, S_BEAT, S_HOLD} st_t;

  st_t st;
  logic wr_q, io_q, burst_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [CW-1:0] cnt;
  logic bad, busy;

  assign bad  = req_burst && (req_io || req_addr[ALB-1:0] != '0);
  assign busy = (st == S_ADDR) || (st == S_SNGL) || (st == S_BEAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      wr_q <= 1'b0;
      io_q <= 1'b0;
      burst_q <= 1'b0;
      addr_q <= '0;
      wdata_q <= '0;
      cnt <= '0;
      rsp_rdata <= '0;
      rsp_beat <= 1'b0;
      rsp_done <= 1'b0;
      rsp_err <= 1'b0;
      irq_seen <= 1'b0;
    end else begin
      rsp_beat <= 1'b0;
      rsp_done <= 1'b0;
      rsp_err  <= 1'b0;
      case (st)
        S_IDLE: begin
          irq_seen <= irq_in;
          if (hold_req) st <= S_HOLD;
          else if (req_valid) begin
            if (bad) rsp_err <= 1'b1;
            else begin
              wr_q <= req_write;
              io_q <= req_io;
              burst_q <= req_burst;
              addr_q <= req_addr;
              wdata_q <= req_wdata;
              cnt <= '0;
              st <= S_ADDR;
            end
          end
        end
        S_ADDR: st <= burst_q ? S_BEAT : S_SNGL;
        S_SNGL: if (bus_ready) begin
          rsp_beat <= 1'b1;
          rsp_done <= 1'b1;
          if (!wr_q) rsp_rdata <= bus_rdata;
          st <= hold_req ? S_HOLD : S_IDLE;
        end
        S_BEAT: if (bus_ready) begin
          rsp_beat <= 1'b1;
          if (!wr_q) rsp_rdata <= bus_rdata;
          cnt <= cnt + 1'b1;
          if (cnt == LAST) begin
            rsp_done <= 1'b1;
            st <= S_IDLE;
          end
        end
        S_HOLD: if (!hold_req) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready     = (st == S_IDLE) && !hold_req;
  assign beat_idx      = cnt;
  assign bus_cyc_start = (st == S_ADDR);
  assign bus_cs        = busy;
  assign bus_addr      = busy ? (addr_q | (AW'(cnt) << LB)) : '0;
  assign bus_status    = busy ? {io_q, wr_q, burst_q, 1'b1} : 4'b0;
  assign bus_data_oe   = wr_q && (((st == S_ADDR) && !burst_q) || (st == S_SNGL) || (st == S_BEAT));
  assign bus_wdata     = (st == S_BEAT) ? beat_wdata : wdata_q;
  assign bus_oe        = (st != S_HOLD);
  assign hold_ack      = (st == S_HOLD);

  a_r2_strobe_once: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc_start |=> !bus_cyc_start);

  a_r5_burst_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc_start && bus_status[1]) |-> (!bus_status[3] && bus_addr[ALB-1:0] == '0));

  a_r5_err_no_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (!bus_cs && !bus_cyc_start));

  a_r3_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SNGL && !bus_ready) |=> (st == S_SNGL && $stable(bus_addr)));

  a_r4_beat_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BEAT && !bus_ready) |=> (st == S_BEAT && $stable(beat_idx)));

  a_r6_hold_release: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ack |-> (!bus_oe && !bus_data_oe && !bus_cs));

  a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  a_r10_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SNGL || st == S_BEAT) |=> $stable(irq_seen));
endmodule

// File: tb/xbus_seq_test.sv
`timescale 1ns/1ps
module xbus_seq_test;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_io = 0, req_burst = 0;
  logic [31:0] req_addr = 0, req_wdata = 0, beat_wdata, bus_rdata = 0;
  logic req_ready, rsp_beat, rsp_done, rsp_err, irq_seen, irq_in = 0;
  logic [1:0] beat_idx;
  logic [31:0] rsp_rdata, bus_addr, bus_wdata;
  logic bus_data_oe, bus_oe, bus_cyc_start, bus_cs, hold_ack;
  logic [3:0] bus_status;
  logic bus_ready = 0, hold_req = 0;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;
  assign beat_wdata = 32'hC0DE_0000 + {30'd0, beat_idx};

  xbus_seq uut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic single(input bit w, input bit io, input logic [31:0] a, input logic [31:0] d,
                        input int waits, input bit hold_end, input bit probe);
    chk(req_ready == 1, "R1 ready", req_ready, 1);
    req_valid = 1; req_write = w; req_io = io; req_burst = 0; req_addr = a; req_wdata = d;
    cyc();
    req_valid = 0;
    chk(bus_cyc_start && bus_cs, "R2 strobe", {bus_cyc_start, bus_cs}, 2'b11);
    chk(bus_addr == a, "R2 addr", bus_addr, a);
    chk(bus_status == {io, w, 1'b0, 1'b1}, "R2 status", bus_status, {io, w, 1'b0, 1'b1});
    chk(bus_data_oe == w, "R2 data_oe", bus_data_oe, w);
    if (w) chk(bus_wdata == d, "R2 wdata", bus_wdata, d);
    if (probe) irq_in = 0;
    for (int i = 0; i <= waits; i++) begin
      cyc();
      chk(!bus_cyc_start && bus_cs && bus_addr == a, "R3 wait", bus_addr, a);
      chk(!rsp_done, "R3 no done", rsp_done, 0);
      if (probe) chk(irq_seen == 1, "R10 irq held", irq_seen, 1);
      bus_ready = (i == waits);
      bus_rdata = d ^ 32'hFFFF_0000;
      hold_req = hold_end && (i == waits);
    end
    cyc();
    bus_ready = 0;
    chk(rsp_done && rsp_beat, "R3 done", {rsp_done, rsp_beat}, 2'b11);
    if (!w) chk(rsp_rdata == (d ^ 32'hFFFF_0000), "R3 rdata", rsp_rdata, d ^ 32'hFFFF_0000);
    if (hold_end) begin
      chk(hold_ack && !bus_oe, "R7 hold direct", {hold_ack, bus_oe}, 2'b10);
      hold_req = 0;
      cyc();
      chk(!hold_ack && bus_oe, "R9 leave hold", {hold_ack, bus_oe}, 2'b01);
    end else begin
      chk(!bus_cs && bus_status == 0 && !bus_data_oe, "R1 idle", bus_status, 0);
    end
    if (probe) begin
      cyc();
      chk(irq_seen == 0, "R10 resample", irq_seen, 0);
    end
  endtask

  task automatic burst(input bit w, input logic [31:0] a, input int seed, input bit hold_mid);
    logic [31:0] last_d;
    req_valid = 1; req_write = w; req_io = 0; req_burst = 1; req_addr = a;
    cyc();
    req_valid = 0;
    chk(bus_cyc_start && bus_status == {1'b0, w, 1'b1, 1'b1}, "R2 burst status", bus_status, {1'b0, w, 1'b1, 1'b1});
    chk(!bus_data_oe, "R2 burst no data", bus_data_oe, 0);
    last_d = 0;
    for (int k = 0; k < 4; k++) begin
      int ws = (k + seed) % 3;
      for (int j = 0; j <= ws; j++) begin
        cyc();
        chk(bus_addr == a + 4 * k && beat_idx == k, "R4 beat addr", bus_addr, a + 4 * k);
        chk(bus_data_oe == w && bus_cs, "R4 beat oe", bus_data_oe, w);
        if (w) chk(bus_wdata == 32'hC0DE_0000 + k, "R4 beat wdata", bus_wdata, 32'hC0DE_0000 + k);
        if (k > 0 && j == 0) begin
          chk(rsp_beat == 1, "R4 beat pulse", rsp_beat, 1);
          if (!w) chk(rsp_rdata == last_d, "R4 beat rdata", rsp_rdata, last_d);
        end else chk(rsp_beat == 0, "R4 no pulse", rsp_beat, 0);
        chk(!hold_ack, "R8 no hold mid", hold_ack, 0);
        bus_ready = (j == ws);
        bus_rdata = a + 32'h0101_0000 * (k + 1);
        last_d = bus_rdata;
        hold_req = hold_mid;
      end
    end
    cyc();
    bus_ready = 0;
    chk(rsp_done && rsp_beat, "R4 done", {rsp_done, rsp_beat}, 2'b11);
    if (!w) chk(rsp_rdata == last_d, "R4 last rdata", rsp_rdata, last_d);
    chk(!bus_cs && !hold_ack && bus_oe, "R8 idle after burst", {bus_cs, hold_ack}, 0);
    if (hold_mid) begin
      cyc();
      chk(hold_ack && !bus_oe, "R6 hold after burst", hold_ack, 1);
      hold_req = 0;
      cyc();
      chk(!hold_ack && bus_oe, "R9 leave hold", hold_ack, 0);
    end
  endtask

  task automatic reject(input bit io, input logic [31:0] a);
    req_valid = 1; req_write = 0; req_io = io; req_burst = 1; req_addr = a;
    cyc();
    req_valid = 0;
    chk(rsp_err == 1, "R5 err", rsp_err, 1);
    chk(!bus_cs && !bus_cyc_start, "R5 no cycle", {bus_cs, bus_cyc_start}, 0);
    cyc();
    chk(rsp_err == 0 && !bus_cs, "R5 err pulse", {rsp_err, bus_cs}, 0);
  endtask

  initial begin
    #500000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    cyc();
    chk(!bus_cs && !bus_cyc_start && bus_status == 0 && !bus_data_oe && req_ready, "R1 reset idle", bus_status, 0);
    chk(!rsp_done && !rsp_err && !hold_ack && bus_oe, "R1 reset outputs", {rsp_done, rsp_err, hold_ack}, 0);

    for (int w = 0; w < 2; w++)
      for (int io = 0; io < 2; io++)
        for (int ws = 0; ws < 4; ws++)
          single(w[0], io[0], 32'h1000_0000 + 32'(ws * 4 + io * 64), 32'hA500_0000 + 32'(w * 16 + io * 8 + ws), ws, 0, 0);

    single(0, 0, 32'h2000_0040, 32'h1234_5678, 2, 1, 0);
    single(1, 1, 32'h0000_0300, 32'h0BAD_F00D, 0, 1, 0);

    irq_in = 1;
    cyc();
    chk(irq_seen == 1, "R10 idle sample", irq_seen, 1);
    single(0, 0, 32'h3000_0000, 32'h5555_AAAA, 2, 0, 1);

    for (int s = 0; s < 3; s++) begin
      burst(0, 32'h4000_0000 + 32'(s * 16), s, 0);
      burst(1, 32'h5000_0100 + 32'(s * 16), s, 0);
    end
    burst(0, 32'h6000_0000, 1, 1);

    reject(1, 32'h7000_0000);
    for (int n = 1; n < 16; n++) reject(0, 32'h7000_0000 + 32'(n));

    hold_req = 1;
    req_valid = 1; req_burst = 0; req_write = 1; req_io = 0; req_addr = 32'h8000_0000;
    cyc();
    chk(hold_ack && !bus_oe && !bus_data_oe, "R6 hold idle", {hold_ack, bus_oe, bus_data_oe}, 3'b100);
    chk(req_ready == 0, "R6 not ready", req_ready, 0);
    cyc();
    chk(hold_ack && !bus_cs && !bus_cyc_start, "R6 request ignored", {bus_cs, bus_cyc_start}, 0);
    hold_req = 0; req_valid = 0;
    cyc();
    chk(!hold_ack && bus_oe && !bus_cs, "R9 back idle", {hold_ack, bus_oe}, 2'b01);

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule